// File: doc/BRIEF.md
# USB Device Endpoint Handshake Engine

This block chooses the handshake a USB 2.0 device port returns to each host token, with no firmware involvement. Once the token decoder has identified a token (IN, OUT, PING or SETUP) and its endpoint number, the engine finds the endpoint slot that owns it. It then compares that slot's FIFO occupancy against the slot's maximum packet size and issues one registered response code. The same comparison drives the FIFO commit strobes that make transferred data permanent.

Slot 0 is the control endpoint and always answers endpoint number 0. The other slots (five by default) each carry an enable, an endpoint number and a direction set by configuration inputs. The engine tracks only one transaction at a time. After it accepts an OUT or SETUP, it waits for the receiver to report the data packet. After it sends data for an IN, it waits for the host's ACK or for a timeout.

Top module: `ep_handshake_engine`

## Requirements
- R1: After reset, `rsp_valid` is low and all three commit strobe vectors are zero.
- R2: Endpoint number 0 selects slot 0 for any token kind. A general slot k (1..NGEN) matches when it is enabled, its number equals the token's nonzero endpoint number, and its direction fits the token: an IN token needs direction-in = 1, and OUT or PING needs direction-in = 0. When several slots match, the lowest index wins. A token that matches no slot, including a SETUP to a nonzero number, produces no response and no strobe.
- R3: An IN token (kind code 0) is answered with DATA (response code 0) when the slot's FIFO data count is at least its max packet size. Otherwise it is answered with NAK (code 2).
- R4: A PING (kind code 2) in high-speed mode is answered with ACK (code 1) when FIFO free space is at least the max packet size, and with NAK otherwise. In full-speed mode a PING gets no response.
- R5: An OUT (kind code 1) with free space below the max packet size is answered with NAK. A following data-packet report then causes no FIFO write commit and no response.
- R6: An OUT with enough free space gets no immediate response. The next `rx_ok` pulses `fifo_wr_commit` for that slot and returns ACK. In high-speed mode it returns NYET (code 3) instead when free space minus `rx_len` is below the max packet size.
- R7: In full-speed mode NYET is never issued. The post-receive handshake is always ACK.
- R8: After DATA is sent, `host_ack` pulses `fifo_rd_commit` for that slot and `host_timeout` pulses `fifo_rd_rewind` for it. Neither produces a response code.
- R9: A SETUP (kind code 3) to endpoint 0 is always accepted, with no NAK. Its data packet is committed and answered with ACK, never NYET.
- R10: `rx_abort` while waiting for a data packet returns the engine to idle with no response and no commit.
- R11: Every response and strobe appears in the cycle after the clock edge that samples its cause.
- R12: Tokens that arrive while the engine waits for a data packet or a host handshake are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_mode | input | 1 | 1 = high speed, 0 = full speed |
| tok_valid | input | 1 | Token strobe, one cycle |
| tok_kind | input | 2 | 0 IN, 1 OUT, 2 PING, 3 SETUP |
| tok_ep | input | EPNW | Token endpoint number |
| rx_ok | input | 1 | Data packet received intact |
| rx_abort | input | 1 | Data packet lost or corrupted |
| rx_len | input | MPSW | Byte count of the received packet |
| host_ack | input | 1 | Host acknowledged sent data |
| host_timeout | input | 1 | No host handshake after sent data |
| cfg_en | input | NGEN | Enable per general slot |
| cfg_num | input | NGEN*EPNW | Endpoint number per general slot |
| cfg_dir_in | input | NGEN | 1 = slot sends data to the host |
| cfg_mps | input | (NGEN+1)*MPSW | Max packet size per slot, slot 0 lowest |
| fifo_count | input | (NGEN+1)*CW | Stored bytes per slot FIFO |
| fifo_free | input | (NGEN+1)*CW | Free bytes per slot FIFO |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | 0 DATA, 1 ACK, 2 NAK, 3 NYET |
| fifo_wr_commit | output | NGEN+1 | Commit received packet, one-hot per slot |
| fifo_rd_commit | output | NGEN+1 | Release sent packet, one-hot per slot |
| fifo_rd_rewind | output | NGEN+1 | Restore read pointer, one-hot per slot |

## Verification
If the engine held a wrong slot index, the fault would show one cycle after the data packet or host handshake: the commit strobe would land on a neighbouring FIFO's bit. A wrong wait state would show as a missing or extra response right after the next `rx_ok` or token. A wrong threshold compare would turn DATA into NAK, or ACK into NYET, at exactly the boundary where the count or free space equals the max packet size, or falls one byte short. The stimulus therefore places FIFO levels on both sides of that boundary, and it reaches the slots that share endpoint numbers and the disabled slots.

// File: rtl/ephs_pkg.sv
package ephs_pkg;
   typedef enum logic [1:0] {TK_IN = 2'd0, TK_OUT = 2'd1, TK_PING = 2'd2, TK_SETUP = 2'd3} tok_e;
   typedef enum logic [1:0] {RS_DATA = 2'd0, RS_ACK = 2'd1, RS_NAK = 2'd2, RS_NYET = 2'd3} rsp_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RXWAIT = 2'd1, ST_TXWAIT = 2'd2} st_e;
endpackage

// File: rtl/ephs_lookup.sv
// Maps a token's endpoint number and direction onto a slot index.
module ephs_lookup #(
   parameter int NGEN      = 5,
   parameter int EPNW      = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int NEP      = NGEN + 1,
   localparam int SW       = $clog2(NEP)
) (
   input  logic [EPNW-1:0]      tok_ep,
   input  logic                 tok_is_in,
   input  logic                 tok_setup,
   input  logic [NGEN-1:0]      cfg_en,
   input  logic [NGEN*EPNW-1:0] cfg_num,
   input  logic [NGEN-1:0]      cfg_dir_in,
   output logic                 hit,
   output logic [SW-1:0]        slot
);
   logic [NEP-1:0] match;

   assign match[0] = (tok_ep == '0);

   for (genvar g = 0; g < NGEN; g++) begin : g_slot
      assign match[g+1] = cfg_en[g] && !tok_setup && (tok_ep != '0) &&
                          (cfg_num[g*EPNW +: EPNW] == tok_ep) &&
                          (cfg_dir_in[g] == tok_is_in);
   end

   assign hit = |match;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         slot = '0;
         for (int i = NEP - 1; i >= 0; i--)
            if (match[i]) slot = SW'(i);
      end
   end else begin : g_high
      always_comb begin
         slot = '0;
         for (int i = 0; i < NEP; i++)
            if (match[i]) slot = SW'(i);
      end
   end
endmodule

// File: rtl/ephs_decide.sv
// Token-time decision from FIFO occupancy against max packet size.
module ephs_decide #(
   parameter int MPSW = 11,
   parameter int CW   = 13
) (
   input  logic [1:0]      kind,
   input  logic            hs,
   input  logic [CW-1:0]   count,
   input  logic [CW-1:0]   free,
   input  logic [MPSW-1:0] mps,
   output logic            rv,
   output logic [1:0]      rk,
   output logic            go_rx,
   output logic            go_tx
);
   import ephs_pkg::*;
   logic [CW-1:0] mps_x;
   logic          data_ready, room_ready;

   assign mps_x      = {{(CW-MPSW){1'b0}}, mps};
   assign data_ready = (count >= mps_x);
   assign room_ready = (free >= mps_x);

   always_comb begin
      rv    = 1'b0;
      rk    = RS_NAK;
      go_rx = 1'b0;
      go_tx = 1'b0;
      case (tok_e'(kind))
         TK_IN: begin
            rv    = 1'b1;
            rk    = data_ready ? RS_DATA : RS_NAK;
            go_tx = data_ready;
         end
         TK_OUT: begin
            rv    = !room_ready;
            rk    = RS_NAK;
            go_rx = room_ready;
         end
         TK_PING: begin
            rv = hs;
            rk = room_ready ? RS_ACK : RS_NAK;
         end
         default: begin
            go_rx = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/ephs_post.sv
// Handshake after an accepted data packet: ACK or, in high speed, NYET.
module ephs_post #(
   parameter int MPSW = 11,
   parameter int CW   = 13
) (
   input  logic            hs,
   input  logic            is_setup,
   input  logic [CW-1:0]   free,
   input  logic [MPSW-1:0] rx_len,
   input  logic [MPSW-1:0] mps,
   output logic [1:0]      rk
);
   import ephs_pkg::*;
   logic [CW-1:0] len_x, mps_x, remain;

   assign len_x  = {{(CW-MPSW){1'b0}}, rx_len};
   assign mps_x  = {{(CW-MPSW){1'b0}}, mps};
   assign remain = (free >= len_x) ? (free - len_x) : '0;
   assign rk     = (hs && !is_setup && (remain < mps_x)) ? RS_NYET : RS_ACK;
endmodule

// File: rtl/ep_handshake_engine.sv
module ep_handshake_engine #(
   parameter int NGEN      = 5,
   parameter int EPNW      = 4,
   parameter int MPSW      = 11,
   parameter int CW        = 13,
   parameter bit LOW_FIRST = 1'b1,
   localparam int NEP      = NGEN + 1,
   localparam int SW       = $clog2(NEP)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hs_mode,
   input  logic                 tok_valid,
   input  logic [1:0]           tok_kind,
   input  logic [EPNW-1:0]      tok_ep,
   input  logic                 rx_ok,
   input  logic                 rx_abort,
   input  logic [MPSW-1:0]      rx_len,
   input  logic                 host_ack,
   input  logic                 host_timeout,
   input  logic [NGEN-1:0]      cfg_en,
   input  logic [NGEN*EPNW-1:0] cfg_num,
   input  logic [NGEN-1:0]      cfg_dir_in,
   input  logic [NEP*MPSW-1:0]  cfg_mps,
   input  logic [NEP*CW-1:0]    fifo_count,
   input  logic [NEP*CW-1:0]    fifo_free,
   output logic                 rsp_valid,
   output logic [1:0]           rsp_kind,
   output logic [NEP-1:0]       fifo_wr_commit,
   output logic [NEP-1:0]       fifo_rd_commit,
   output logic [NEP-1:0]       fifo_rd_rewind
);
   import ephs_pkg::*;

   if (NGEN < 1 || NGEN > 15) begin : g_bad_ngen
      $error("NGEN must lie in 1..15");
   end
   if (EPNW != 4) begin : g_bad_epnw
      $error("EPNW must be 4");
   end
   if (CW <= MPSW) begin : g_bad_cw
      $error("CW must exceed MPSW");
   end

   st_e           state;
   logic [SW-1:0] cur_slot;
   logic          cur_setup;
   logic          busy;

   logic          lk_hit;
   logic [SW-1:0] lk_slot;
   logic          d_rv, d_go_rx, d_go_tx;
   logic [1:0]    d_rk, p_rk;

   assign busy = (state != ST_IDLE);

   ephs_lookup #(
      .NGEN(NGEN), .EPNW(EPNW), .LOW_FIRST(LOW_FIRST)
   ) lookup_i (
      .tok_ep    (tok_ep),
      .tok_is_in (tok_kind == TK_IN),
      .tok_setup (tok_kind == TK_SETUP),
      .cfg_en    (cfg_en),
      .cfg_num   (cfg_num),
      .cfg_dir_in(cfg_dir_in),
      .hit       (lk_hit),
      .slot      (lk_slot)
   );

   ephs_decide #(.MPSW(MPSW), .CW(CW)) decide_i (
      .kind (tok_kind),
      .hs   (hs_mode),
      .count(fifo_count[lk_slot*CW +: CW]),
      .free (fifo_free[lk_slot*CW +: CW]),
      .mps  (cfg_mps[lk_slot*MPSW +: MPSW]),
      .rv   (d_rv),
      .rk   (d_rk),
      .go_rx(d_go_rx),
      .go_tx(d_go_tx)
   );

   ephs_post #(.MPSW(MPSW), .CW(CW)) post_i (
      .hs      (hs_mode),
      .is_setup(cur_setup),
      .free    (fifo_free[cur_slot*CW +: CW]),
      .rx_len  (rx_len),
      .mps     (cfg_mps[cur_slot*MPSW +: MPSW]),
      .rk      (p_rk)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state          <= ST_IDLE;
         cur_slot       <= '0;
         cur_setup      <= 1'b0;
         rsp_valid      <= 1'b0;
         rsp_kind       <= RS_NAK;
         fifo_wr_commit <= '0;
         fifo_rd_commit <= '0;
         fifo_rd_rewind <= '0;
      end else begin
         rsp_valid      <= 1'b0;
         fifo_wr_commit <= '0;
         fifo_rd_commit <= '0;
         fifo_rd_rewind <= '0;
         case (state)
            ST_IDLE: begin
               if (tok_valid && lk_hit) begin
                  rsp_valid <= d_rv;
                  rsp_kind  <= d_rk;
                  cur_slot  <= lk_slot;
                  cur_setup <= (tok_kind == TK_SETUP);
                  if (d_go_rx)      state <= ST_RXWAIT;
                  else if (d_go_tx) state <= ST_TXWAIT;
               end
            end
            ST_RXWAIT: begin
               if (rx_abort) begin
                  state <= ST_IDLE;
               end else if (rx_ok) begin
                  rsp_valid                <= 1'b1;
                  rsp_kind                 <= p_rk;
                  fifo_wr_commit[cur_slot] <= 1'b1;
                  state                    <= ST_IDLE;
               end
            end
            ST_TXWAIT: begin
               if (host_ack) begin
                  fifo_rd_commit[cur_slot] <= 1'b1;
                  state                    <= ST_IDLE;
               end else if (host_timeout) begin
                  fifo_rd_rewind[cur_slot] <= 1'b1;
                  state                    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ephs_checker.sv
module ephs_checker #(
   parameter int NEP = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic           hs_mode,
   input logic           tok_valid,
   input logic [1:0]     tok_kind,
   input logic           rx_ok,
   input logic           host_ack,
   input logic           host_timeout,
   input logic           busy,
   input logic           rsp_valid,
   input logic [1:0]     rsp_kind,
   input logic [NEP-1:0] fifo_wr_commit,
   input logic [NEP-1:0] fifo_rd_commit,
   input logic [NEP-1:0] fifo_rd_rewind
);
   p_one_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fifo_wr_commit, fifo_rd_commit, fifo_rd_rewind}));

   p_nyet_hs_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'd3) |-> $past(hs_mode));

   p_data_from_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'd0) |-> $past(tok_valid && tok_kind == 2'd0));

   p_fs_ping_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_kind == 2'd2 && !hs_mode && !busy) |=> !rsp_valid);

   p_wr_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|fifo_wr_commit) |-> (rsp_valid && (rsp_kind == 2'd1 || rsp_kind == 2'd3)));

   p_rd_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|fifo_rd_commit) |-> $past(host_ack));

   p_busy_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rx_ok && !host_ack && !host_timeout) |=> !rsp_valid);
endmodule

bind ep_handshake_engine ephs_checker #(.NEP(NEP)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .hs_mode       (hs_mode),
   .tok_valid     (tok_valid),
   .tok_kind      (tok_kind),
   .rx_ok         (rx_ok),
   .host_ack      (host_ack),
   .host_timeout  (host_timeout),
   .busy          (busy),
   .rsp_valid     (rsp_valid),
   .rsp_kind      (rsp_kind),
   .fifo_wr_commit(fifo_wr_commit),
   .fifo_rd_commit(fifo_rd_commit),
   .fifo_rd_rewind(fifo_rd_rewind)
);

// File: tb/ep_handshake_engine_tb_top.sv
`timescale 1ns/1ps
module ep_handshake_engine_tb_top;
   localparam int NGEN = 5, EPNW = 4, MPSW = 11, CW = 13, NEP = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic                 hs_mode = 1'b1, tok_valid = 1'b0;
   logic [1:0]           tok_kind = '0;
   logic [EPNW-1:0]      tok_ep = '0;
   logic                 rx_ok = 1'b0, rx_abort = 1'b0, host_ack = 1'b0, host_timeout = 1'b0;
   logic [MPSW-1:0]      rx_len = '0;
   logic [NGEN-1:0]      cfg_en, cfg_dir_in;
   logic [NGEN*EPNW-1:0] cfg_num;
   logic [NEP*MPSW-1:0]  cfg_mps;
   logic [NEP*CW-1:0]    fifo_count, fifo_free;
   logic                 rsp_valid;
   logic [1:0]           rsp_kind;
   logic [NEP-1:0]       fifo_wr_commit, fifo_rd_commit, fifo_rd_rewind;

   int b_en[NEP], b_num[NEP], b_dir[NEP], b_mps[NEP], cnt[NEP], fre[NEP];
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always_comb begin
      for (int i = 1; i < NEP; i++) begin
         cfg_en[i-1]                 = b_en[i][0];
         cfg_dir_in[i-1]             = b_dir[i][0];
         cfg_num[(i-1)*EPNW +: EPNW] = b_num[i][EPNW-1:0];
      end
      for (int i = 0; i < NEP; i++) begin
         cfg_mps[i*MPSW +: MPSW] = b_mps[i][MPSW-1:0];
         fifo_count[i*CW +: CW]  = cnt[i][CW-1:0];
         fifo_free[i*CW +: CW]   = fre[i][CW-1:0];
      end
   end

   ep_handshake_engine #(.NGEN(NGEN), .EPNW(EPNW), .MPSW(MPSW), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .tok_valid(tok_valid),
      .tok_kind(tok_kind), .tok_ep(tok_ep), .rx_ok(rx_ok), .rx_abort(rx_abort),
      .rx_len(rx_len), .host_ack(host_ack), .host_timeout(host_timeout),
      .cfg_en(cfg_en), .cfg_num(cfg_num), .cfg_dir_in(cfg_dir_in), .cfg_mps(cfg_mps),
      .fifo_count(fifo_count), .fifo_free(fifo_free), .rsp_valid(rsp_valid),
      .rsp_kind(rsp_kind), .fifo_wr_commit(fifo_wr_commit),
      .fifo_rd_commit(fifo_rd_commit), .fifo_rd_rewind(fifo_rd_rewind)
   );

   // Slot lookup model: lowest matching slot, -1 when none.
   function automatic int find_slot(int kind, int ep);
      if (ep == 0) return 0;
      if (kind == 3) return -1;
      for (int i = 1; i < NEP; i++)
         if (b_en[i] != 0 && b_num[i] == ep && b_dir[i] == ((kind == 0) ? 1 : 0)) return i;
      return -1;
   endfunction

   function automatic int post_kind(int s, int len, bit hs, bit setup);
      int rem;
      rem = (fre[s] >= len) ? fre[s] - len : 0;
      return (hs && !setup && rem < b_mps[s]) ? 3 : 1;
   endfunction

   task automatic chk(bit ev, int ek, int ewr, int erd, int erw, string tag);
      bit ok;
      ok = (rsp_valid == ev) && (!ev || rsp_kind == ek[1:0]) &&
           (fifo_wr_commit == ewr[NEP-1:0]) && (fifo_rd_commit == erd[NEP-1:0]) &&
           (fifo_rd_rewind == erw[NEP-1:0]);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got v=%0b k=%0d wr=%b rd=%b rw=%b, want v=%0b k=%0d wr=%b rd=%b rw=%b",
                  tag, rsp_valid, rsp_kind, fifo_wr_commit, fifo_rd_commit, fifo_rd_rewind,
                  ev, ek, ewr[NEP-1:0], erd[NEP-1:0], erw[NEP-1:0]);
      end
   endtask

   // Drive one input pulse for one cycle, sample the registered result at the next negedge.
   task automatic token(int kind, int ep);
      @(negedge clk);
      tok_valid = 1'b1; tok_kind = kind[1:0]; tok_ep = ep[EPNW-1:0];
      @(negedge clk);
      tok_valid = 1'b0;
   endtask

   task automatic pulse_rx(bit ok, int len);
      @(negedge clk);
      rx_ok = ok; rx_abort = !ok; rx_len = len[MPSW-1:0];
      @(negedge clk);
      rx_ok = 1'b0; rx_abort = 1'b0;
   endtask

   task automatic pulse_host(bit ack);
      @(negedge clk);
      host_ack = ack; host_timeout = !ack;
      @(negedge clk);
      host_ack = 1'b0; host_timeout = 1'b0;
   endtask

   // Full transaction against the model; abort/ack choices given by caller.
   task automatic transact(int kind, int ep, bit abort_rx, bit ack, int len, string tag);
      int s, ek;
      bit ev, rxw, txw;
      s = find_slot(kind, ep);
      ev = 0; ek = 0; rxw = 0; txw = 0;
      if (s >= 0) begin
         case (kind)
            0: begin ev = 1; ek = (cnt[s] >= b_mps[s]) ? 0 : 2; txw = (ek == 0); end
            1: begin ev = (fre[s] < b_mps[s]); ek = 2; rxw = !ev; end
            2: begin ev = hs_mode; ek = (fre[s] >= b_mps[s]) ? 1 : 2; end
            default: rxw = 1;
         endcase
      end
      token(kind, ep);
      chk(ev, ek, 0, 0, 0, tag);
      if (rxw) begin
         pulse_rx(!abort_rx, len);
         if (abort_rx) chk(0, 0, 0, 0, 0, "R10 abort");
         else chk(1, post_kind(s, len, hs_mode, kind == 3), 1 << s, 0, 0,
                  hs_mode ? "R6 post-receive" : "R7 fs post-receive");
      end else if (kind == 1 && s >= 0) begin
         pulse_rx(1'b1, len);
         chk(0, 0, 0, 0, 0, "R5 discarded data");
      end
      if (txw) begin
         pulse_host(ack);
         chk(0, 0, 0, ack ? (1 << s) : 0, ack ? 0 : (1 << s), "R8 host result");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got hang, want completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      b_mps = '{64, 64, 512, 8, 64, 32};
      b_num = '{0, 1, 2, 3, 2, 1};
      b_dir = '{0, 1, 0, 1, 1, 1};
      b_en  = '{0, 1, 1, 1, 1, 1};
      for (int i = 0; i < NEP; i++) begin cnt[i] = 0; fre[i] = 4000; end
      repeat (3) @(negedge clk);
      chk(0, 0, 0, 0, 0, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(0, 0, 0, 0, 0, "R1 after release");

      // Directed boundaries
      hs_mode = 1'b1;
      cnt[1] = 63; transact(0, 1, 0, 1, 0, "R3 IN one short");
      cnt[1] = 64; transact(0, 1, 0, 1, 0, "R3 IN exact");
      transact(0, 1, 0, 0, 0, "R3 IN timeout path");
      fre[2] = 511; transact(2, 2, 0, 1, 0, "R4 PING short");
      fre[2] = 512; transact(2, 2, 0, 1, 0, "R4 PING exact");
      hs_mode = 1'b0; transact(2, 2, 0, 1, 0, "R4 PING fs silent");
      hs_mode = 1'b1;
      fre[2] = 100; transact(1, 2, 0, 1, 100, "R5 OUT NAK");
      fre[2] = 1024; transact(1, 2, 0, 1, 512, "R6 ACK remain exact");
      fre[2] = 1023; transact(1, 2, 0, 1, 512, "R6 NYET remain short");
      hs_mode = 1'b0; transact(1, 2, 0, 1, 512, "R7 fs no NYET");
      hs_mode = 1'b1;
      fre[0] = 0; transact(3, 0, 0, 1, 8, "R9 SETUP accepted");
      transact(3, 2, 0, 1, 8, "R2 SETUP nonzero ep");
      transact(1, 2, 1, 1, 8, "R10 OUT then abort");
      transact(0, 7, 0, 1, 0, "R2 unknown ep");
      cnt[4] = 100; transact(0, 2, 0, 1, 0, "R2 IN on shared number");
      cnt[1] = 0; cnt[5] = 500; transact(0, 1, 0, 1, 0, "R2 lowest slot wins");
      b_en[1] = 0; transact(0, 1, 0, 1, 0, "R2 disabled slot skipped");
      b_en[1] = 1;

      // R12: token while waiting for data is ignored, then data still lands
      fre[2] = 4000;
      token(1, 2); chk(0, 0, 0, 0, 0, "R11 OUT accept silent");
      cnt[1] = 64; token(0, 1); chk(0, 0, 0, 0, 0, "R12 token while busy");
      pulse_rx(1'b1, 10); chk(1, 1, 1 << 2, 0, 0, "R12 data after ignored token");

      // Random mix
      for (int n = 0; n < 400; n++) begin
         int kind, ep, len;
         hs_mode = $urandom_range(0, 1);
         for (int i = 0; i < NEP; i++) begin
            case ($urandom_range(0, 3))
               0: begin cnt[i] = b_mps[i] - 1; fre[i] = b_mps[i] - 1; end
               1: begin cnt[i] = b_mps[i];     fre[i] = b_mps[i]; end
               2: begin cnt[i] = b_mps[i] + $urandom_range(0, 3); fre[i] = 2 * b_mps[i] + $urandom_range(0, 3) - 2; end
               default: begin cnt[i] = $urandom_range(0, 4000); fre[i] = $urandom_range(0, 4000); end
            endcase
            if (cnt[i] < 0) cnt[i] = 0;
            if (fre[i] < 0) fre[i] = 0;
         end
         kind = $urandom_range(0, 3);
         ep = $urandom_range(0, 7);
         len = $urandom_range(0, 512);
         if (find_slot(kind, ep) >= 0 && len > b_mps[find_slot(kind, ep)])
            len = b_mps[find_slot(kind, ep)];
         transact(kind, ep, $urandom_range(0, 5) == 0, $urandom_range(0, 1), len, "R3 R6 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule